// File: doc/BRIEF.md
# Streaming Matrix-Vector Multiplier

This block computes y = A·x for a square signed-integer matrix of dimension N. It exchanges data over three valid/ready streams: one carries the matrix, one carries the vector and one returns the result. A transaction has three phases, always in the same order.

In the load phase the block accepts the whole matrix, one element per beat, and stores it in registers. In the multiply phase it accepts one vector element per beat. Each element goes at once to every row's multiply-accumulate unit, so the vector never has to be stored. In the drain phase the block sends the N row sums in row order and flags the final one. The next transaction starts with a fresh full matrix load.

The phase controller has three named states:
- `ST_LOAD` moves to `ST_MAC` on the handshake of the final matrix beat (row N-1, column N-1).
- `ST_MAC` moves to `ST_DRAIN` on the handshake of vector element N-1.
- `ST_DRAIN` moves back to `ST_LOAD` on the handshake of result N-1.

Reset enters `ST_LOAD`. In each state the block stays put on any cycle without a handshake.

Top module: `mvm_stream`

## Requirements
- R1: Matrix beats are stored row-major: beat k of the N*N load phase becomes element A[k/N][k%N], with the column index wrapping from N-1 to 0 before the row index advances.
- R2: `mat_tready` is high only in the load phase, `vec_tready` only in the multiply phase, and both are low during the drain phase.
- R3: On each accepted vector beat j, every row i adds A[i][j]·x[j] to its own accumulator in that same cycle, so result i equals the sum over j of A[i][j]·x[j].
- R4: All row accumulators are cleared at the first matrix beat of each transaction, so no sum from an earlier transaction leaks into a later one.
- R5: The result is sent as N beats with y[0] first. `res_tlast` is 1 only on y[N-1], and `res_tkeep` is all ones on every beat.
- R6: A beat without a handshake changes nothing. While `res_tvalid` is high and `res_tready` is low, `res_tdata` and `res_tlast` hold their values.
- R7: A valid beat offered on the stream whose phase is not active is not accepted and does not disturb the stored matrix, the sums or the beat counts.
- R8: Arithmetic is signed two's complement. The result width 2*DW+clog2(N) holds the extreme case where every element is the most negative DW-bit value, without overflow.
- R9: After reset the block is in the load phase: `mat_tready` is 1, `vec_tready` is 0 and `res_tvalid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mat_tdata | input | DW | Matrix element, signed |
| mat_tvalid | input | 1 | Matrix beat valid |
| mat_tready | output | 1 | Matrix beat accepted when high with valid |
| vec_tdata | input | DW | Vector element, signed |
| vec_tvalid | input | 1 | Vector beat valid |
| vec_tready | output | 1 | Vector beat accepted when high with valid |
| res_tdata | output | OW | Row sum, signed |
| res_tvalid | output | 1 | Result beat valid |
| res_tready | input | 1 | Downstream accepts result beat |
| res_tlast | output | 1 | Marks result y[N-1] |
| res_tkeep | output | OW/8 rounded up | Byte enables, all ones |

## Verification
The bench targets the following corner cases and the failure each one exposes:
- A zero matrix right after a transaction with huge sums. A design that fails to clear its accumulators returns the stale totals.
- A matrix and vector made entirely of the most negative value. This exposes unsigned products or a truncated accumulator, which produce a wrong sign or a wrapped value.
- Vector beats offered during the load phase, and matrix beats offered during the multiply phase. A design whose ready signals are not gated by the phase would swallow these beats and shift every later row or column.
- Random valid gaps and result back-pressure. A design that advances on valid alone, or changes its output while stalled, would skip or repeat results and fail the order and last-flag checks.

// File: rtl/mvm_pkg.sv
package mvm_pkg;

    typedef enum logic [1:0] {
        ST_LOAD  = 2'd0,
        ST_MAC   = 2'd1,
        ST_DRAIN = 2'd2
    } phase_t;

endpackage

// File: rtl/mvm_phase_ctrl.sv
module mvm_phase_ctrl
    import mvm_pkg::*;
#(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mat_tvalid,
    input  logic          vec_tvalid,
    input  logic          res_tready,
    output logic          mat_tready,
    output logic          vec_tready,
    output logic          res_tvalid,
    output logic          res_tlast,
    output logic          mat_we,
    output logic          mac_en,
    output logic          acc_clr,
    output logic [IW-1:0] row_idx,
    output logic [IW-1:0] col_idx
);

    localparam logic [IW-1:0] LAST = IW'(N - 1);

    phase_t        state, state_n;
    logic [IW-1:0] row_n, col_n;

    // state and index registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_LOAD;
            row_idx <= '0;
            col_idx <= '0;
        end else begin
            state   <= state_n;
            row_idx <= row_n;
            col_idx <= col_n;
        end
    end

    // next state and outputs
    always_comb begin
        state_n    = state;
        row_n      = row_idx;
        col_n      = col_idx;
        mat_tready = 1'b0;
        vec_tready = 1'b0;
        res_tvalid = 1'b0;
        res_tlast  = 1'b0;
        mat_we     = 1'b0;
        mac_en     = 1'b0;
        acc_clr    = 1'b0;
        unique case (state)
            ST_LOAD: begin
                mat_tready = 1'b1;
                if (mat_tvalid) begin
                    mat_we  = 1'b1;
                    acc_clr = (row_idx == '0) && (col_idx == '0);
                    if (col_idx == LAST) begin
                        col_n = '0;
                        if (row_idx == LAST) begin
                            row_n   = '0;
                            state_n = ST_MAC;
                        end else begin
                            row_n = row_idx + 1'b1;
                        end
                    end else begin
                        col_n = col_idx + 1'b1;
                    end
                end
            end
            ST_MAC: begin
                vec_tready = 1'b1;
                if (vec_tvalid) begin
                    mac_en = 1'b1;
                    if (col_idx == LAST) begin
                        col_n   = '0;
                        state_n = ST_DRAIN;
                    end else begin
                        col_n = col_idx + 1'b1;
                    end
                end
            end
            ST_DRAIN: begin
                res_tvalid = 1'b1;
                res_tlast  = (row_idx == LAST);
                if (res_tready) begin
                    if (row_idx == LAST) begin
                        row_n   = '0;
                        state_n = ST_LOAD;
                    end else begin
                        row_n = row_idx + 1'b1;
                    end
                end
            end
            default: begin
                state_n = ST_LOAD;
                row_n   = '0;
                col_n   = '0;
            end
        endcase
    end

    // R6: idle input leaves the load position untouched
    p_load_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD && !mat_tvalid) |=> ($stable(row_idx) && $stable(col_idx) && state == ST_LOAD));

    // R1: final matrix beat opens the vector phase
    p_load_to_mac_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mat_tvalid && mat_tready && row_idx == LAST && col_idx == LAST) |=> (vec_tready && !mat_tready));

    // R5: after the last result is taken the next load begins
    p_last_to_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_tvalid && res_tready && res_tlast) |=> (mat_tready && !res_tvalid));

    // R2: ready signals of the two inputs never overlap
    p_ready_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mat_tready, vec_tready, res_tvalid}));

endmodule

// File: rtl/mvm_mat_store.sv
module mvm_mat_store #(
    parameter int N  = 4,
    parameter int DW = 16,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic                  clk,
    input  logic                  we,
    input  logic [IW-1:0]         wr_row,
    input  logic [IW-1:0]         wr_col,
    input  logic [DW-1:0]         wr_data,
    input  logic [IW-1:0]         rd_col,
    output logic [N-1:0][DW-1:0]  col_out
);

    for (genvar r = 0; r < N; r++) begin : g_row
        logic [DW-1:0] cells [N];

        always_ff @(posedge clk) begin
            if (we && wr_row == IW'(r)) begin
                cells[wr_col] <= wr_data;
            end
        end

        assign col_out[r] = cells[rd_col];
    end

endmodule

// File: rtl/mvm_row_mac.sv
module mvm_row_mac #(
    parameter int DW = 16,
    parameter int OW = 34
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic [DW-1:0] a_elem,
    input  logic [DW-1:0] x_elem,
    output logic [OW-1:0] acc
);

    localparam int PW = 2 * DW;

    logic signed [PW-1:0] prod;
    logic        [OW-1:0] prod_ext;

    assign prod     = $signed(a_elem) * $signed(x_elem);
    assign prod_ext = {{(OW - PW){prod[PW-1]}}, prod};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (clr) begin
            acc <= '0;
        end else if (en) begin
            acc <= acc + prod_ext;
        end
    end

    // R4: a clear empties the accumulator on the next cycle
    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc == '0));

    // R6: no update without an enable or clear
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !en) |=> $stable(acc));

endmodule

// File: rtl/mvm_stream.sv
module mvm_stream #(
    parameter int N  = 4,
    parameter int DW = 16,
    parameter int OW = 2 * DW + ((N > 1) ? $clog2(N) : 1),
    parameter int KW = (OW + 7) / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] mat_tdata,
    input  logic          mat_tvalid,
    output logic          mat_tready,
    input  logic [DW-1:0] vec_tdata,
    input  logic          vec_tvalid,
    output logic          vec_tready,
    output logic [OW-1:0] res_tdata,
    output logic          res_tvalid,
    input  logic          res_tready,
    output logic          res_tlast,
    output logic [KW-1:0] res_tkeep
);

    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic                 mat_we, mac_en, acc_clr;
    logic [IW-1:0]        row_idx, col_idx;
    logic [N-1:0][DW-1:0] col_vec;
    logic [N-1:0][OW-1:0] sums;

    mvm_phase_ctrl #(.N(N), .IW(IW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .mat_tvalid (mat_tvalid),
        .vec_tvalid (vec_tvalid),
        .res_tready (res_tready),
        .mat_tready (mat_tready),
        .vec_tready (vec_tready),
        .res_tvalid (res_tvalid),
        .res_tlast  (res_tlast),
        .mat_we     (mat_we),
        .mac_en     (mac_en),
        .acc_clr    (acc_clr),
        .row_idx    (row_idx),
        .col_idx    (col_idx)
    );

    mvm_mat_store #(.N(N), .DW(DW), .IW(IW)) u_store (
        .clk     (clk),
        .we      (mat_we),
        .wr_row  (row_idx),
        .wr_col  (col_idx),
        .wr_data (mat_tdata),
        .rd_col  (col_idx),
        .col_out (col_vec)
    );

    for (genvar r = 0; r < N; r++) begin : g_mac
        mvm_row_mac #(.DW(DW), .OW(OW)) u_mac (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (acc_clr),
            .en     (mac_en),
            .a_elem (col_vec[r]),
            .x_elem (vec_tdata),
            .acc    (sums[r])
        );
    end

    assign res_tdata = sums[row_idx];
    assign res_tkeep = '1;

    // R6: a stalled result beat keeps its content
    p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_tvalid && !res_tready) |=> (res_tvalid && $stable(res_tdata) && $stable(res_tlast)));

    // R2: inputs are closed while results drain
    p_drain_closed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        res_tvalid |-> (!mat_tready && !vec_tready));

endmodule

// File: tb/mvm_stream_tb.sv
module mvm_stream_tb;

    localparam int N  = 4;
    localparam int DW = 16;
    localparam int OW = 2 * DW + $clog2(N);
    localparam int KW = (OW + 7) / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] mat_tdata = '0;
    logic          mat_tvalid = 1'b0;
    logic          mat_tready;
    logic [DW-1:0] vec_tdata = '0;
    logic          vec_tvalid = 1'b0;
    logic          vec_tready;
    logic [OW-1:0] res_tdata;
    logic          res_tvalid;
    logic          res_tready = 1'b0;
    logic          res_tlast;
    logic [KW-1:0] res_tkeep;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    int A [N][N];
    int X [N];

    always #2 clk = ~clk;

    mvm_stream #(.N(N), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .mat_tdata(mat_tdata), .mat_tvalid(mat_tvalid), .mat_tready(mat_tready),
        .vec_tdata(vec_tdata), .vec_tvalid(vec_tvalid), .vec_tready(vec_tready),
        .res_tdata(res_tdata), .res_tvalid(res_tvalid), .res_tready(res_tready),
        .res_tlast(res_tlast), .res_tkeep(res_tkeep)
    );

    function automatic longint expect_row(int r);
        longint s = 0;
        for (int j = 0; j < N; j++) s += longint'(A[r][j]) * longint'(X[j]);
        return s;
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send_mat(int d);
        repeat ($urandom % 3) @(negedge clk);
        mat_tdata  = DW'(d);
        mat_tvalid = 1'b1;
        while (!mat_tready) @(negedge clk);
        @(negedge clk);
        mat_tvalid = 1'b0;
    endtask

    task automatic send_vec(int d);
        repeat ($urandom % 3) @(negedge clk);
        vec_tdata  = DW'(d);
        vec_tvalid = 1'b1;
        while (!vec_tready) @(negedge clk);
        @(negedge clk);
        vec_tvalid = 1'b0;
    endtask

    task automatic get_res();
        int            got = 0;
        bit            stalled = 1'b0;
        logic [OW-1:0] held = '0;
        while (got < N) begin
            res_tready = ($urandom % 4) != 0;
            #0;
            if (res_tvalid) begin
                chk(!mat_tready && !vec_tready, "R2 inputs closed in drain",
                    {mat_tready, vec_tready}, 0);
                if (stalled) chk(res_tdata == held, "R6 stalled result held",
                                 longint'($signed(res_tdata)), longint'($signed(held)));
                if (res_tready) begin
                    chk(longint'($signed(res_tdata)) == expect_row(got), "R3 R1 R8 row sum",
                        longint'($signed(res_tdata)), expect_row(got));
                    chk(res_tlast == (got == N - 1), "R5 last flag", res_tlast, got == N - 1);
                    chk(res_tkeep == '1, "R5 keep all ones", res_tkeep, {KW{1'b1}});
                    got++;
                    stalled = 1'b0;
                end else begin
                    stalled = 1'b1;
                    held    = res_tdata;
                end
            end
            @(negedge clk);
        end
        res_tready = 1'b0;
    endtask

    task automatic run_txn(bit inject);
        for (int r = 0; r < N; r++) begin
            for (int c = 0; c < N; c++) begin
                if (inject && r == 1 && c == 0) begin
                    // R7: vector beats offered during matrix load
                    vec_tdata  = DW'(16'h7abc);
                    vec_tvalid = 1'b1;
                    repeat (2) begin
                        @(negedge clk);
                        chk(!vec_tready, "R7 vector refused in load", vec_tready, 0);
                    end
                    vec_tvalid = 1'b0;
                end
                send_mat(A[r][c]);
            end
        end
        for (int j = 0; j < N; j++) begin
            if (inject && j == 1) begin
                // R7: matrix beats offered during multiply
                mat_tdata  = DW'(16'h5555);
                mat_tvalid = 1'b1;
                repeat (2) begin
                    @(negedge clk);
                    chk(!mat_tready, "R7 matrix refused in multiply", mat_tready, 0);
                end
                mat_tvalid = 1'b0;
            end
            send_vec(X[j]);
        end
        get_res();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(mat_tready && !vec_tready && !res_tvalid, "R9 phase during reset",
            {mat_tready, vec_tready, res_tvalid}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mat_tready && !vec_tready && !res_tvalid, "R9 reset state",
            {mat_tready, vec_tready, res_tvalid}, 3'b100);

        // R1 R3: identity with signed vector
        for (int r = 0; r < N; r++) begin
            for (int c = 0; c < N; c++) A[r][c] = (r == c) ? 1 : 0;
            X[r] = (r % 2 == 0) ? (r + 1) : -(r + 1);
        end
        run_txn(1'b0);

        // R1: distinct entries reveal row-major placement
        for (int r = 0; r < N; r++) begin
            for (int c = 0; c < N; c++) A[r][c] = r * N + c;
            X[r] = 1 << (3 * r);
        end
        run_txn(1'b1);

        // R8: most negative everywhere
        for (int r = 0; r < N; r++) begin
            for (int c = 0; c < N; c++) A[r][c] = -32768;
            X[r] = -32768;
        end
        run_txn(1'b0);

        // R4: zero matrix right after huge sums
        for (int r = 0; r < N; r++) begin
            for (int c = 0; c < N; c++) A[r][c] = 0;
            X[r] = 32767;
        end
        run_txn(1'b0);

        // R3 R6 R7: random data, random gaps and back-pressure
        for (int t = 0; t < 24; t++) begin
            for (int r = 0; r < N; r++) begin
                for (int c = 0; c < N; c++) A[r][c] = int'($signed(16'($urandom)));
                X[r] = int'($signed(16'($urandom)));
            end
            run_txn(t % 5 == 0);
        end

        @(negedge clk);
        chk(mat_tready && !res_tvalid, "R9 back in load phase", mat_tready, 1);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule